// File: doc/BRIEF.md
# Single-Wire Debug Entry Sequencer

This block runs on the debug host and orders the steps that bring a target into single-wire debug mode after the target has first answered. It waits for the calibration unit to report that a synchronization frame has been measured. It then holds the line idle-high for a guard time and asks an external bit-transfer engine to write the debug control word. After that write it releases the target reset and waits for the target to load its configuration and settle. When recalibration is enabled, it finally asks the engine for a communication reset and waits for a second, more trustworthy, sync-frame measurement.

A single start pulse launches the sequence. Each transfer is a request held high until the engine acknowledges it. Every wait that depends on another unit is bounded by a timeout in host clock cycles. When such a wait runs out, the sequencer stops in an error state and reports which wait failed. A successful run ends with a one-cycle done pulse. In either case the sequencer stays where it is until the next start pulse.

Top module: `wire_dbg_entry`

## Requirements
- R1: After reset, xferReq, guardBusy, targetRstRelease, donePulse and errFlag are 0, errCode is 0 and xferData is 0.
- R2: A start pulse in the idle, finished or error state begins a wait for calValid. While that wait runs, no transfer is requested and the target reset stays held. A start pulse during any other step has no effect.
- R3: One cycle after calValid is sampled in the first wait, guardBusy is high for exactly GUARD_CYC cycles with xferReq low. xferReq rises in the cycle after guardBusy falls.
- R4: The first request has xferKind 0 (control write) and xferData 0xA0: bit 7 set (internal target reset sources masked), bit 5 set (full memory and system-reset access), all other bits 0. The request is held until xferAck.
- R5: targetRstRelease rises in the cycle after the control write is acknowledged, never earlier. It stays high through the rest of a successful run and while the finished state holds.
- R6: After the reset release, exactly SETTLE_CYC cycles pass. With RECAL_EN = 1 a request with xferKind 1 (communication reset) and xferData 0 follows and is held until xferAck. With RECAL_EN = 0 the run finishes directly.
- R7: After the communication reset is acknowledged, the sequencer waits for a new calValid pulse. A calValid pulse that arrives outside the two calibration waits has no effect.
- R8: donePulse is high for exactly one cycle, in the cycle after the final step completes. It does not repeat until a new run completes.
- R9: If calValid does not arrive within CAL_TO cycles of entering a calibration wait, errFlag rises. errCode is 1 for the first wait and 3 for the second.
- R10: If xferAck does not arrive within ACK_TO cycles of a request rising, the request drops, errFlag rises and errCode is 2.
- R11: In the error state xferReq and targetRstRelease are 0. A new start pulse clears errFlag and errCode and restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begins an entry sequence |
| calValid | input | 1 | Pulse: a sync frame has been measured |
| xferReq | output | 1 | Transfer request to the bit engine |
| xferKind | output | 1 | 0 = control write, 1 = communication reset |
| xferData | output | 8 | Control word for the write transfer |
| xferAck | input | 1 | Bit engine has completed the request |
| guardBusy | output | 1 | Line held idle-high for the guard time |
| targetRstRelease | output | 1 | Releases the target reset |
| donePulse | output | 1 | One-cycle pulse at successful completion |
| errFlag | output | 1 | Sequence stopped on a timeout |
| errCode | output | 2 | 1 first calibration, 2 acknowledge, 3 recalibration |

## Verification
The bench builds the sequencer with GUARD_CYC = 5, SETTLE_CYC = 20, ACK_TO = 16, CAL_TO = 30 and RECAL_EN = 1. At the default values the settle window alone would take 250,000 cycles, so these small values bring every timeout and every window edge within a few dozen cycles. That lets the bench count each window cycle by cycle, pick random delays anywhere inside each window, and drive each of the four timeout paths to its exact expiry cycle.

// File: rtl/wde_pkg.sv
package wde_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CAL1,
    ST_GUARD,
    ST_WRITE,
    ST_SETTLE,
    ST_COMRST,
    ST_CAL2,
    ST_DONE,
    ST_HOLD,
    ST_ERR
  } seqState_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_CAL   = 2'd1,
    ERR_ACK   = 2'd2,
    ERR_RECAL = 2'd3
  } errCode_t;

  typedef enum logic [1:0] {
    WIN_CAL,
    WIN_GUARD,
    WIN_ACK,
    WIN_SETTLE
  } winSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     tmrClr;
    winSel_t  winSel;
    logic     rstSet;
    logic     rstClr;
    logic     errLatch;
    errCode_t errVal;
    logic     errClr;
  } dpCmd_t;

  localparam int MASK_RST_BIT   = 7;
  localparam int FULL_ACC_BIT   = 5;
  localparam logic [7:0] CTRL_WORD = 8'((1 << MASK_RST_BIT) | (1 << FULL_ACC_BIT));

endpackage

// File: rtl/wde_datapath.sv
module wde_datapath
  import wde_pkg::*;
#(
  parameter int GUARD_CYC  = 75,
  parameter int SETTLE_CYC = 250000,
  parameter int ACK_TO     = 4096,
  parameter int CAL_TO     = 65536
) (
  input  logic     clk,
  input  logic     rstN,
  input  dpCmd_t   cmd,
  output logic     winExpired,
  output logic     targetRstRelease,
  output errCode_t errCode
);

  localparam int MAX_AB  = (GUARD_CYC > SETTLE_CYC) ? GUARD_CYC : SETTLE_CYC;
  localparam int MAX_CD  = (ACK_TO > CAL_TO) ? ACK_TO : CAL_TO;
  localparam int MAX_WIN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW      = $clog2(MAX_WIN + 1);

  logic [CW-1:0] winCnt;
  logic [CW-1:0] winLimit;

  always_comb begin
    unique case (cmd.winSel)
      WIN_CAL:    winLimit = CW'(CAL_TO - 1);
      WIN_GUARD:  winLimit = CW'(GUARD_CYC - 1);
      WIN_ACK:    winLimit = CW'(ACK_TO - 1);
      WIN_SETTLE: winLimit = CW'(SETTLE_CYC - 1);
      default:    winLimit = '0;
    endcase
  end

  assign winExpired = (winCnt == winLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (cmd.tmrClr) begin
      winCnt <= '0;
    end else if (!winExpired) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetRstRelease <= 1'b0;
    end else if (cmd.rstClr) begin
      targetRstRelease <= 1'b0;
    end else if (cmd.rstSet) begin
      targetRstRelease <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCode <= ERR_NONE;
    end else if (cmd.errClr) begin
      errCode <= ERR_NONE;
    end else if (cmd.errLatch) begin
      errCode <= cmd.errVal;
    end
  end

  // window counter never runs past the largest window
  p_win_bounded_r3: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= CW'(MAX_WIN))
    else $error("window counter beyond largest window");

  // counter only moves by one or restarts
  p_win_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.tmrClr && !winExpired |=> winCnt == $past(winCnt) + 1'b1)
    else $error("window counter skipped");

  // a latched error code is never ERR_NONE
  p_err_nonzero_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.errLatch && !cmd.errClr |=> errCode != ERR_NONE)
    else $error("error latched without a cause");

endmodule

// File: rtl/wde_ctrl.sv
module wde_ctrl
  import wde_pkg::*;
#(
  parameter bit RECAL_EN = 1'b1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startPulse,
  input  logic   calValid,
  input  logic   xferAck,
  input  logic   winExpired,
  output dpCmd_t cmd,
  output logic   xferReq,
  output logic   xferKind,
  output logic   guardBusy,
  output logic   donePulse,
  output logic   errFlag
);

  seqState_t st, stNext;
  errCode_t  errCause;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext   = st;
    errCause = ERR_NONE;
    unique case (st)
      ST_IDLE, ST_HOLD, ST_ERR: begin
        if (startPulse) stNext = ST_CAL1;
      end
      ST_CAL1: begin
        if (calValid) stNext = ST_GUARD;
        else if (winExpired) begin
          stNext   = ST_ERR;
          errCause = ERR_CAL;
        end
      end
      ST_GUARD: begin
        if (winExpired) stNext = ST_WRITE;
      end
      ST_WRITE: begin
        if (xferAck) stNext = ST_SETTLE;
        else if (winExpired) begin
          stNext   = ST_ERR;
          errCause = ERR_ACK;
        end
      end
      ST_SETTLE: begin
        if (winExpired) stNext = RECAL_EN ? ST_COMRST : ST_DONE;
      end
      ST_COMRST: begin
        if (xferAck) stNext = ST_CAL2;
        else if (winExpired) begin
          stNext   = ST_ERR;
          errCause = ERR_ACK;
        end
      end
      ST_CAL2: begin
        if (calValid) stNext = ST_DONE;
        else if (winExpired) begin
          stNext   = ST_ERR;
          errCause = ERR_RECAL;
        end
      end
      ST_DONE: stNext = ST_HOLD;
      default: stNext = ST_IDLE;
    endcase
  end

  logic leaving;
  logic restarting;
  assign leaving    = (stNext != st);
  assign restarting = leaving && (stNext == ST_CAL1);

  always_comb begin
    cmd          = '0;
    cmd.tmrClr   = leaving || (st == ST_IDLE) || (st == ST_HOLD) ||
                   (st == ST_ERR) || (st == ST_DONE);
    unique case (st)
      ST_GUARD:             cmd.winSel = WIN_GUARD;
      ST_WRITE, ST_COMRST:  cmd.winSel = WIN_ACK;
      ST_SETTLE:            cmd.winSel = WIN_SETTLE;
      default:              cmd.winSel = WIN_CAL;
    endcase
    cmd.rstSet   = (st == ST_WRITE) && (stNext == ST_SETTLE);
    cmd.rstClr   = restarting || (leaving && stNext == ST_ERR);
    cmd.errLatch = leaving && (stNext == ST_ERR);
    cmd.errVal   = errCause;
    cmd.errClr   = restarting;
  end

  assign xferReq   = (st == ST_WRITE) || (st == ST_COMRST);
  assign xferKind  = (st == ST_COMRST);
  assign guardBusy = (st == ST_GUARD);
  assign donePulse = (st == ST_DONE);
  assign errFlag   = (st == ST_ERR);

  // the write request is only ever entered from the guard window
  p_req_after_guard_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferReq) && !xferKind |-> $past(st) == ST_GUARD)
    else $error("control write without guard time");

  // an unacknowledged request stays up unless its window expired
  p_req_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && !xferAck && !winExpired |=> xferReq && $stable(xferKind))
    else $error("request dropped before acknowledge");

  // a start pulse mid-sequence leaves the state untouched
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && (st == ST_GUARD || st == ST_WRITE || st == ST_SETTLE ||
                   st == ST_COMRST) |=> st != ST_CAL1)
    else $error("start honoured while busy");

  // the final calibration wait is reached only through an acknowledged reset request
  p_recal_after_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st == ST_CAL2) |-> $past(xferAck) && $past(xferKind))
    else $error("recalibration wait without reset request");

  // done lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse)
    else $error("done longer than one cycle");

  // error and done are exclusive
  p_err_done_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(errFlag && (donePulse || xferReq || guardBusy)))
    else $error("error state overlaps activity");

endmodule

// File: rtl/wire_dbg_entry.sv
module wire_dbg_entry
  import wde_pkg::*;
#(
  parameter int GUARD_CYC  = 75,
  parameter int SETTLE_CYC = 250000,
  parameter int ACK_TO     = 4096,
  parameter int CAL_TO     = 65536,
  parameter bit RECAL_EN   = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       calValid,
  output logic       xferReq,
  output logic       xferKind,
  output logic [7:0] xferData,
  input  logic       xferAck,
  output logic       guardBusy,
  output logic       targetRstRelease,
  output logic       donePulse,
  output logic       errFlag,
  output logic [1:0] errCode
);

  dpCmd_t   dpCmd;
  logic     winExpired;
  errCode_t errCodeInt;

  wde_ctrl #(
    .RECAL_EN (RECAL_EN)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .calValid   (calValid),
    .xferAck    (xferAck),
    .winExpired (winExpired),
    .cmd        (dpCmd),
    .xferReq    (xferReq),
    .xferKind   (xferKind),
    .guardBusy  (guardBusy),
    .donePulse  (donePulse),
    .errFlag    (errFlag)
  );

  wde_datapath #(
    .GUARD_CYC  (GUARD_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .ACK_TO     (ACK_TO),
    .CAL_TO     (CAL_TO)
  ) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .cmd              (dpCmd),
    .winExpired       (winExpired),
    .targetRstRelease (targetRstRelease),
    .errCode          (errCodeInt)
  );

  assign errCode  = errCodeInt;
  assign xferData = (xferReq && !xferKind) ? CTRL_WORD : 8'h00;

  // reset released only after an acknowledged control write
  p_rst_after_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(targetRstRelease) |-> $past(xferReq && xferAck && !xferKind))
    else $error("target reset released early");

  // error state never leaves the target released or a request pending
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !targetRstRelease && !xferReq)
    else $error("error state not quiet");

  // an error always carries a cause
  p_err_has_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> errCode != 2'd0)
    else $error("error without code");

endmodule

// File: tb/wire_dbg_entry_bench.sv
`timescale 1ns/1ps
module wire_dbg_entry_bench;

  localparam int GUARD_CYC  = 5;
  localparam int SETTLE_CYC = 20;
  localparam int ACK_TO     = 16;
  localparam int CAL_TO     = 30;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic       calValid = 1'b0;
  logic       xferAck = 1'b0;
  logic       xferReq, xferKind, guardBusy, targetRstRelease, donePulse, errFlag;
  logic [7:0] xferData;
  logic [1:0] errCode;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wire_dbg_entry #(
    .GUARD_CYC  (GUARD_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .ACK_TO     (ACK_TO),
    .CAL_TO     (CAL_TO),
    .RECAL_EN   (1'b1)
  ) u_wire_dbg_entry (
    .clk              (clk),
    .rstN             (rstN),
    .startPulse       (startPulse),
    .calValid         (calValid),
    .xferReq          (xferReq),
    .xferKind         (xferKind),
    .xferData         (xferData),
    .xferAck          (xferAck),
    .guardBusy        (guardBusy),
    .targetRstRelease (targetRstRelease),
    .donePulse        (donePulse),
    .errFlag          (errFlag),
    .errCode          (errCode)
  );

  function automatic logic [7:0] expWord();
    logic [7:0] w = '0;
    w[7] = 1'b1;
    w[5] = 1'b1;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulseStart();
    startPulse = 1'b1;
    tick();
    startPulse = 1'b0;
  endtask

  // hold ack off for d cycles with request checked, then acknowledge
  task automatic ackAfter(input int d, input string req);
    for (int i = 0; i < d; i++) begin
      chk(xferReq == 1'b1, req, xferReq, 1);
      tick();
    end
    xferAck = 1'b1;
    tick();
    xferAck = 1'b0;
  endtask

  // count cycles until errFlag is seen
  task automatic countToErr(output int n);
    n = 0;
    while (!errFlag && n < 500) begin
      n++;
      tick();
    end
  endtask

  // mode 0 full run, 1 no cal, 2 no write ack, 3 no reset ack, 4 no recal
  task automatic runSeq(input int mode, input bit inject);
    int n;
    int d;
    pulseStart();
    // in first calibration wait
    chk(xferReq == 1'b0 && targetRstRelease == 1'b0, "R2", targetRstRelease, 0);
    chk(errFlag == 1'b0 && errCode == 2'd0, "R11", errCode, 0);
    if (mode == 1) begin
      countToErr(n);
      chk(n == CAL_TO, "R9", n, CAL_TO);
      chk(errCode == 2'd1, "R9", errCode, 1);
      chk(xferReq == 1'b0 && targetRstRelease == 1'b0, "R11", xferReq, 0);
      return;
    end
    d = $urandom_range(CAL_TO - 3, 0);
    repeat (d) tick();
    chk(guardBusy == 1'b0, "R2", guardBusy, 0);
    calValid = 1'b1;
    tick();
    calValid = 1'b0;
    // guard window
    n = 0;
    while (guardBusy && n < 100) begin
      if (n == 0 && inject) begin
        startPulse = 1'b1;
        calValid   = 1'b1;
      end else begin
        startPulse = 1'b0;
        calValid   = 1'b0;
      end
      chk(xferReq == 1'b0, "R3", xferReq, 0);
      n++;
      tick();
    end
    startPulse = 1'b0;
    calValid   = 1'b0;
    chk(n == GUARD_CYC, inject ? "R2" : "R3", n, GUARD_CYC);
    chk(xferReq == 1'b1 && xferKind == 1'b0, "R4", xferKind, 0);
    chk(xferData == expWord(), "R4", xferData, expWord());
    chk(targetRstRelease == 1'b0, "R5", targetRstRelease, 0);
    if (mode == 2) begin
      n = 0;
      while (xferReq && n < 100) begin n++; tick(); end
      chk(n == ACK_TO, "R10", n, ACK_TO);
      chk(errFlag == 1'b1 && errCode == 2'd2, "R10", errCode, 2);
      chk(targetRstRelease == 1'b0, "R11", targetRstRelease, 0);
      return;
    end
    ackAfter($urandom_range(ACK_TO - 2, 0), "R4");
    chk(targetRstRelease == 1'b1 && xferReq == 1'b0, "R5", targetRstRelease, 1);
    // settle window, with a stray calibration pulse
    n = 0;
    while (targetRstRelease && !xferReq && n < 200) begin
      calValid = (n == 3);
      n++;
      tick();
    end
    calValid = 1'b0;
    chk(n == SETTLE_CYC, "R6", n, SETTLE_CYC);
    chk(xferReq == 1'b1 && xferKind == 1'b1, "R6", xferKind, 1);
    chk(xferData == 8'h00, "R6", xferData, 0);
    if (mode == 3) begin
      n = 0;
      while (xferReq && n < 100) begin n++; tick(); end
      chk(n == ACK_TO, "R10", n, ACK_TO);
      chk(errFlag == 1'b1 && errCode == 2'd2, "R10", errCode, 2);
      chk(targetRstRelease == 1'b0, "R11", targetRstRelease, 0);
      return;
    end
    ackAfter($urandom_range(ACK_TO - 2, 0), "R6");
    if (mode == 4) begin
      countToErr(n);
      chk(n == CAL_TO, "R9", n, CAL_TO);
      chk(errCode == 2'd3, "R9", errCode, 3);
      chk(targetRstRelease == 1'b0, "R11", targetRstRelease, 0);
      return;
    end
    d = $urandom_range(CAL_TO - 3, 0);
    for (int i = 0; i < d; i++) begin
      chk(donePulse == 1'b0 && targetRstRelease == 1'b1, "R7", donePulse, 0);
      tick();
    end
    calValid = 1'b1;
    tick();
    calValid = 1'b0;
    chk(donePulse == 1'b1, "R8", donePulse, 1);
    chk(errFlag == 1'b0 && errCode == 2'd0, "R8", errCode, 0);
    tick();
    chk(donePulse == 1'b0, "R8", donePulse, 0);
    // stray calibration while finished must not restart anything
    calValid = 1'b1;
    tick();
    calValid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(donePulse == 1'b0 && xferReq == 1'b0, "R8", donePulse, 0);
      chk(targetRstRelease == 1'b1, "R5", targetRstRelease, 1);
      tick();
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    tick();
    chk(xferReq == 0 && guardBusy == 0 && targetRstRelease == 0, "R1", xferReq, 0);
    chk(donePulse == 0 && errFlag == 0 && errCode == 0 && xferData == 0, "R1", errCode, 0);
    rstN = 1'b1;
    repeat (3) tick();
    // a stray calibration pulse while idle
    calValid = 1'b1;
    tick();
    calValid = 1'b0;
    repeat (2) tick();
    chk(guardBusy == 0 && xferReq == 0, "R7", guardBusy, 0);
    runSeq(0, 1'b0);
    runSeq(0, 1'b1);
    for (int k = 0; k < 4; k++) runSeq(0, k[0]);
    runSeq(1, 1'b0);
    runSeq(0, 1'b0);
    runSeq(2, 1'b0);
    runSeq(3, 1'b1);
    runSeq(4, 1'b0);
    runSeq(0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule